// File: doc/BRIEF.md
# Multi-format serial audio port

This block is the slave-side digital audio serial interface of a stereo converter. An external master supplies the bit clock and the word-select clock. The block never drives frame timing. It takes stereo playback samples from a serial data input and turns them into parallel left and right words. In the other direction, it takes parallel left and right record samples and shifts them out on a separate serial data output. Each frame carries one stereo pair, so both directions run at one sample pair per sample period.

The frame convention is a static selection: I2S, MSB-justified or LSB-justified. For the LSB-justified convention, a second static selection sets the word length to 16, 18 or 20 bits. The bit clock, word select and serial input are brought into the block's own clock domain through synchronisers. Edges of the bit clock are then detected as one-cycle events. For this reason the system clock must run several times faster than the bit clock.

Top module: `audio_serial_port`

## Requirements
- R1: The serial input and word select are sampled at rising bit-clock edges. The serial output changes only in the cycle after a falling bit-clock edge has been detected. Word select low marks the left channel and high marks the right channel.
- R2: With fmt = 0 (I2S), the MSB of each word is in the second bit period after a word-select change, one period later than the change itself. This holds in both directions.
- R3: With fmt = 1 (MSB-justified), the MSB of each word is in the first bit period after a word-select change, with no delay.
- R4: With fmt = 2 (LSB-justified), the LSB of each received word is in the last bit period before the next word-select change. The word length is set by lsb_len: 0 gives 16 bits, 1 gives 18 bits, and 2 or 3 gives 20 bits. Bits that arrive before the word in the half-frame are ignored.
- R5: Received words shorter than 20 bits are left-aligned in the 20-bit parallel word, with zeros in the unused low bits. Bits after the 20th bit of a half-frame are discarded.
- R6: When the right word of a pair is complete, rx_left and rx_right are updated together and rx_valid is high for exactly one clock. At all other times the two words hold their values. The first rx_valid after reset follows the first complete left-then-right pair.
- R7: tx_left and tx_right are both latched when the left word of a frame starts. They are shifted out MSB first. In I2S and MSB-justified modes, every bit period after the 20th is driven low.
- R8: In LSB-justified mode, the output word ends in the last bit period of the half-frame. The length of the half-frame is taken from the half-frame just finished. The periods before the word carry copies of the word's MSB (sign extension).
- R9: While reset is asserted, and after it until the first bit-clock activity, sdo, rx_valid, rx_left and rx_right are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the bit-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Frame convention: 0 I2S, 1 MSB-justified, 2 or 3 LSB-justified |
| lsb_len | input | 2 | LSB-justified word length: 0 = 16, 1 = 18, 2 or 3 = 20 bits |
| bck | input | 1 | Bit clock from the external master |
| ws | input | 1 | Word select from the external master, low = left |
| sdi | input | 1 | Serial playback data in |
| sdo | output | 1 | Serial record data out |
| rx_left | output | W | Received left word, left-aligned |
| rx_right | output | W | Received right word, left-aligned |
| rx_valid | output | 1 | One-clock strobe when a received pair is updated |
| tx_left | input | W | Left record sample, latched at frame start |
| tx_right | input | W | Right record sample, latched at frame start |

## Verification
The bench uses the default parameters: a 20-bit word, a 6-bit half-frame counter and two synchroniser stages. The bit clock runs at one sixteenth of the system clock. Half-frames of 16, 20, 24 and 32 bit periods are tested. The 16-period I2S case exercises zero padding. A 24-bit word in a 32-period half-frame exercises discarding bits beyond 20. In LSB mode, 32 periods with a 16-bit word gives a long ignored lead-in and a long sign-extension lead-in, while 20 periods with a 20-bit word gives none.

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
  parameter int W    = 20,
  parameter int CW   = 6,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   fmt,
  input  logic [1:0]   lsb_len,
  input  logic         bck,
  input  logic         ws,
  input  logic         sdi,
  output logic         sdo,
  output logic [W-1:0] rx_left,
  output logic [W-1:0] rx_right,
  output logic         rx_valid,
  input  logic [W-1:0] tx_left,
  input  logic [W-1:0] tx_right
);
  localparam int IW = $clog2(W + 1);
  localparam int LW = ((CW > IW) ? CW : IW) + 1;

  logic [SYNC-1:0] bck_p, ws_p, sdi_p;
  logic bck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_p <= '0;
      ws_p  <= '0;
      sdi_p <= '0;
      bck_q <= 1'b0;
    end else begin
      bck_p <= {bck_p[SYNC-2:0], bck};
      ws_p  <= {ws_p[SYNC-2:0], ws};
      sdi_p <= {sdi_p[SYNC-2:0], sdi};
      bck_q <= bck_p[SYNC-1];
    end
  end

  wire bck_s = bck_p[SYNC-1];
  wire ws_s  = ws_p[SYNC-1];
  wire sdi_s = sdi_p[SYNC-1];
  wire brise = bck_s & ~bck_q;
  wire bfall = ~bck_s & bck_q;
  wire is_i2s = (fmt == 2'd0);
  wire is_lsb = fmt[1];

  logic [IW-1:0] lsb_l;
  always_comb begin
    case (lsb_len)
      2'd0:    lsb_l = IW'(16);
      2'd1:    lsb_l = IW'(18);
      default: lsb_l = IW'(20);
    endcase
  end

  // receive side
  logic ws_r1, rw_prev, started, have_left;
  logic [IW-1:0] rcnt;
  logic [W-1:0] acc, sh, left_hold;

  wire rw     = is_i2s ? ws_r1 : ws_s;
  wire rbound = (rw != rw_prev);
  wire [W-1:0] lsb_word = sh << (IW'(W) - lsb_l);
  wire [W-1:0] fin_word = is_lsb ? lsb_word : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_r1     <= 1'b0;
      rw_prev   <= 1'b0;
      started   <= 1'b0;
      have_left <= 1'b0;
      rcnt      <= '0;
      acc       <= '0;
      sh        <= '0;
      left_hold <= '0;
      rx_left   <= '0;
      rx_right  <= '0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (brise) begin
        ws_r1   <= ws_s;
        rw_prev <= rw;
        sh      <= {sh[W-2:0], sdi_s};
        if (rbound) begin
          started <= 1'b1;
          if (started) begin
            if (!rw_prev) begin
              left_hold <= fin_word;
              have_left <= 1'b1;
            end else if (have_left) begin
              rx_left   <= left_hold;
              rx_right  <= fin_word;
              rx_valid  <= 1'b1;
              have_left <= 1'b0;
            end
          end
          acc  <= {sdi_s, {(W-1){1'b0}}};
          rcnt <= IW'(1);
        end else if (rcnt < IW'(W)) begin
          acc  <= acc | ({sdi_s, {(W-1){1'b0}}} >> rcnt);
          rcnt <= rcnt + 1'b1;
        end
      end
    end
  end

  // transmit side
  logic ws_f1, tw_prev, tch, sdo_r;
  logic [CW-1:0] tcnt, hlen;
  logic [W-1:0] txl_q, txr_q;

  wire tw     = is_i2s ? ws_f1 : ws_s;
  wire tbound = (tw != tw_prev);

  logic [CW-1:0] tk, hl;
  logic [W-1:0]  cur, shifted;
  logic [LW-1:0] k_e, h_e, l_e, amt;
  logic          ch, sign_zone, tbit;

  always_comb begin
    tk  = tbound ? '0 : tcnt;
    hl  = tbound ? tcnt : hlen;
    ch  = tbound ? tw : tch;
    cur = ch ? txr_q : (tbound ? tx_left : txl_q);
    k_e = LW'(tk);
    h_e = LW'(hl);
    l_e = LW'(lsb_l);
    amt = k_e;
    sign_zone = 1'b0;
    if (is_lsb) begin
      if (h_e >= l_e) begin
        if (k_e < h_e - l_e) sign_zone = 1'b1;
        else                 amt = k_e - (h_e - l_e);
      end else begin
        amt = k_e + (l_e - h_e);
      end
    end
    shifted = cur << amt;
    tbit = sign_zone ? cur[W-1] : shifted[W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_f1   <= 1'b0;
      tw_prev <= 1'b0;
      tch     <= 1'b0;
      sdo_r   <= 1'b0;
      tcnt    <= '0;
      hlen    <= '0;
      txl_q   <= '0;
      txr_q   <= '0;
    end else if (bfall) begin
      ws_f1   <= ws_s;
      tw_prev <= tw;
      sdo_r   <= tbit;
      if (tbound) begin
        tch  <= tw;
        tcnt <= CW'(1);
        hlen <= tcnt;
        if (!tw) begin
          txl_q <= tx_left;
          txr_q <= tx_right;
        end
      end else if (tcnt != '1) begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign sdo = sdo_r;
endmodule

// File: rtl/asp_checker.sv
module asp_checker #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rx_valid,
  input logic [W-1:0] rx_left,
  input logic [W-1:0] rx_right,
  input logic         sdo,
  input logic         bfall,
  input logic [1:0]   fmt,
  input logic [1:0]   lsb_len
);
  // R6: strobe lasts one clock
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6: received words move only with the strobe
  p_hold_words_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_left) && $stable(rx_right)));

  // R1: serial output changes only after a detected falling bit-clock edge
  p_sdo_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bfall |=> $stable(sdo));

  // R5: a 16-bit LSB-justified word is zero padded at the low end
  p_pad16_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fmt[1] && lsb_len == 2'd0) |-> (rx_left[W-17:0] == '0 && rx_right[W-17:0] == '0));

  // R4: an 18-bit LSB-justified word leaves the two bits below it clear
  p_pad18_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fmt[1] && lsb_len == 2'd1) |-> (rx_left[W-19:0] == '0 && rx_right[W-19:0] == '0));
endmodule

bind audio_serial_port asp_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_left(rx_left),
  .rx_right(rx_right), .sdo(sdo), .bfall(bfall), .fmt(fmt), .lsb_len(lsb_len)
);

// File: tb/tb_audio_serial_port.sv
module tb_audio_serial_port;
  localparam int W    = 20;
  localparam int FR   = 5;
  localparam int MAXS = FR * 2 * 32 + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] fmt = 2'd0, lsb_len = 2'd0;
  logic bck = 1'b0, ws = 1'b0, sdi = 1'b0;
  logic sdo, rx_valid;
  logic [W-1:0] rx_left, rx_right;
  logic [W-1:0] tx_left = '0, tx_right = '0;

  audio_serial_port dut (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .lsb_len(lsb_len), .bck(bck), .ws(ws),
    .sdi(sdi), .sdo(sdo), .rx_left(rx_left), .rx_right(rx_right),
    .rx_valid(rx_valid), .tx_left(tx_left), .tx_right(tx_right)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [2*W-1:0] rxq[$];
  logic [2*W-1:0] exp_pair;
  string cur_tag = "R9";
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  function automatic logic [W-1:0] align(logic [31:0] d, int ln);
    logic [31:0] v;
    v = d << (32 - ln);
    return v[31:32-W];
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops expected pairs as the design strobes them
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (rxq.size() == 0) check(1'b0, {cur_tag, " R6 unexpected rx_valid"}, {rx_left, rx_right}, 64'd0);
      else begin
        exp_pair = rxq.pop_front();
        check({rx_left, rx_right} == exp_pair, {cur_tag, " R6 received pair"}, {rx_left, rx_right}, exp_pair);
      end
    end
  end

  task automatic run_group(input logic [1:0] f_fmt, input logic [1:0] f_len,
                           input int n, input int len, input string tag);
    int L, off, total, idx, fr, h, p;
    bit lsb;
    logic [31:0] dl[FR], dr[FR], dd;
    logic [W-1:0] tl[FR], tr[FR], wv;
    logic in_s[MAXS];
    logic cap[MAXS];
    logic [63:0] a, e;
    L   = (f_len == 2'd0) ? 16 : (f_len == 2'd1) ? 18 : 20;
    lsb = f_fmt[1];
    off = (f_fmt == 2'd0) ? 1 : 0;
    total = FR * 2 * n;
    cur_tag = tag;
    @(negedge clk);
    rst_n = 1'b0; fmt = f_fmt; lsb_len = f_len; bck = 1'b0; ws = 1'b0; sdi = 1'b0;
    repeat (4) @(negedge clk);
    check(rx_valid == 0 && sdo == 0 && rx_left == 0 && rx_right == 0, "R9 state in reset",
          {rx_valid, sdo, rx_left, rx_right}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rx_valid == 0 && sdo == 0 && rx_left == 0 && rx_right == 0, "R9 state after reset",
          {rx_valid, sdo, rx_left, rx_right}, 64'd0);
    for (int f = 0; f < FR; f++) begin
      rng = nxt(rng); dl[f] = rng;
      rng = nxt(rng); dr[f] = rng;
      rng = nxt(rng); tl[f] = rng[W-1:0];
      rng = nxt(rng); tr[f] = rng[W+5:6];
    end
    for (int i = 0; i < MAXS; i++) begin in_s[i] = 1'b0; cap[i] = 1'b0; end
    for (int f = 0; f < FR; f++)
      for (int hh = 0; hh < 2; hh++)
        for (int k = 0; k < n; k++) begin
          idx = (f * 2 + hh) * n + k + off;
          dd = hh ? dr[f] : dl[f];
          if (idx < total) begin
            if (lsb) in_s[idx] = (k < n - L) ? 1'b1 : dd[L - 1 - (k - (n - L))];
            else     in_s[idx] = (k < len) ? dd[len - 1 - k] : 1'b0;
          end
        end
    for (int f = 1; f < FR - 1; f++)
      rxq.push_back({align(dl[f], lsb ? L : len), align(dr[f], lsb ? L : len)});
    tx_left = tl[0]; tx_right = tr[0];
    for (int i = 0; i < total; i++) begin
      fr = i / (2 * n); h = (i / n) % 2; p = i % n;
      bck = 1'b0; ws = h[0]; sdi = in_s[i];
      if (h == 1 && p == n / 2 && fr + 1 < FR) begin
        tx_left = tl[fr + 1]; tx_right = tr[fr + 1];
      end
      repeat (8) @(negedge clk);
      cap[i] = sdo;
      bck = 1'b1;
      repeat (8) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    check(rxq.size() == 0, {tag, " R6 all pairs delivered"}, 64'(rxq.size()), 64'd0);
    rxq.delete();
    for (int f = 1; f < FR - 1; f++)
      for (int hh = 0; hh < 2; hh++) begin
        a = '0; e = '0;
        wv = hh ? tr[f] : tl[f];
        for (int k = 0; k < n; k++) begin
          a[k] = cap[(f * 2 + hh) * n + k + off];
          if (lsb) e[k] = (k < n - L) ? wv[W-1] : wv[W - 1 - (k - (n - L))];
          else     e[k] = (k < W) ? wv[W - 1 - k] : 1'b0;
        end
        check(a == e, lsb ? {tag, " R1 R8 serial output half"} : {tag, " R1 R7 serial output half"}, a, e);
      end
  endtask

  initial begin
    run_group(2'd0, 2'd2, 32, 20, "R2 i2s n32");
    run_group(2'd0, 2'd2, 16, 16, "R2 R5 i2s n16 pad");
    run_group(2'd1, 2'd2, 32, 24, "R3 R5 msb discard");
    run_group(2'd1, 2'd2, 24, 18, "R3 msb n24");
    run_group(2'd2, 2'd0, 32, 16, "R4 lsb16");
    run_group(2'd2, 2'd1, 24, 18, "R4 lsb18");
    run_group(2'd2, 2'd2, 32, 20, "R4 lsb20 n32");
    run_group(2'd3, 2'd3, 20, 20, "R4 lsb20 n20");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule